// File: doc/BRIEF.md
# Requester ID to MSI Specifier Translator

This block turns the 16-bit Requester ID of a PCIe function into the sideband word that goes with that function's MSI writes to a selected interrupt controller. The 16-bit ID is laid out as bus in bits [15:8], device in bits [7:3] and function in bits [2:0]. A small programmable table describes the translation. Each entry covers a contiguous window of IDs and names one controller. It supplies a base value that is added to the ID's offset within the window.

Software, or a configuration sequencer, loads the table, a global ID mask and a vector of entry enables through a simple write port. The MSI path then issues lookups that carry an ID and a controller index. One clock later the block returns either the translated specifier or a miss. A miss means the selected controller cannot be reached by that function. Entries that cover the same ID for different controllers are independent, so one function can present a different specifier to each controller.

Top module: `rid_msi_xlate`

## Requirements
- R1: After reset every entry is disabled and the global mask is 0xFFFF. Every lookup then misses, and rsp_valid stays low while reset is asserted.
- R2: rsp_valid is high in the cycle after a cycle with lk_valid high, and low after a cycle with lk_valid low.
- R3: Before any comparison, the incoming ID is ANDed bitwise with the global mask, and the masked value is used both for matching and for the specifier.
- R4: An entry matches a masked ID r when base <= r < base + length, with the sum formed without truncation. A length of 0x10000 covers every ID, and a length of 0 matches nothing.
- R5: On a hit, rsp_spec equals (r - base) + msi_base, taken modulo 2^32.
- R6: An entry takes part only in lookups whose lk_ctrl equals its controller index. Entries for different controllers that cover the same ID each give their own specifier.
- R7: When no enabled entry for the requested controller matches, rsp_hit is 0 and rsp_spec is 0.
- R8: When several enabled entries for the requested controller match, the entry with the lowest index decides the result.
- R9: A write with cfg_we high updates one item, selected by cfg_field. Code 0 sets the entry base from wdata[15:0]. Code 1 sets the entry controller from wdata[1:0]. Code 2 sets the entry msi_base from wdata[31:0]. Code 3 sets the entry length from wdata[16:0]. Code 4 sets the global mask from wdata[15:0]. Code 5 sets the enable vector from wdata[7:0], with bit i enabling entry i. Codes 6 and 7 change nothing. cfg_idx selects the entry for codes 0 to 3.
- R10: A table write in the same cycle as a lookup does not affect that lookup; it affects lookups in later cycles.
- R11: An entry whose enable bit is clear never matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_field | input | 3 | Item selector for the write |
| cfg_idx | input | 3 | Entry selected by the write |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request strobe |
| lk_rid | input | 16 | Requester ID to translate |
| lk_ctrl | input | 2 | Target controller index |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_hit | output | 1 | 1 when an entry matched |
| rsp_spec | output | 32 | Translated specifier, 0 on a miss |

## Verification
Every lookup result is registered once, so the bench drives a request on a falling edge and reads rsp_valid, rsp_hit and rsp_spec on the next falling edge, which is exactly one rising edge later. A table write also takes one rising edge. The bench updates its reference table only after that edge, so expected values always reflect the table as it stood when the request was captured. The same timing is used to check the collision case, where a write and a lookup share a cycle: the lookup is expected to see the old table and the following lookup the new one.

// File: rtl/rid_msi_xlate.sv
module rid_msi_xlate #(
  parameter int ENTRIES = 8,
  parameter int RID_W   = 16,
  parameter int SPEC_W  = 32,
  parameter int CTRL_W  = 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int LEN_W  = RID_W + 1,
  localparam int CMP_W  = RID_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_field,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SPEC_W-1:0] cfg_wdata,
  input  logic              lk_valid,
  input  logic [RID_W-1:0]  lk_rid,
  input  logic [CTRL_W-1:0] lk_ctrl,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [SPEC_W-1:0] rsp_spec
);

  logic [RID_W-1:0]  base_q [ENTRIES];
  logic [CTRL_W-1:0] ctrl_q [ENTRIES];
  logic [SPEC_W-1:0] msi_q  [ENTRIES];
  logic [LEN_W-1:0]  len_q  [ENTRIES];
  logic [ENTRIES-1:0] en_q;
  logic [RID_W-1:0]  mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        base_q[i] <= '0;
        ctrl_q[i] <= '0;
        msi_q[i]  <= '0;
        len_q[i]  <= '0;
      end
      en_q   <= '0;
      mask_q <= '1;
    end else if (cfg_we) begin
      case (cfg_field)
        3'd0: base_q[cfg_idx] <= cfg_wdata[RID_W-1:0];
        3'd1: ctrl_q[cfg_idx] <= cfg_wdata[CTRL_W-1:0];
        3'd2: msi_q[cfg_idx]  <= cfg_wdata;
        3'd3: len_q[cfg_idx]  <= cfg_wdata[LEN_W-1:0];
        3'd4: mask_q          <= cfg_wdata[RID_W-1:0];
        3'd5: en_q            <= cfg_wdata[ENTRIES-1:0];
        default: ;
      endcase
    end
  end

  wire [RID_W-1:0] rid_m = lk_rid & mask_q;
  wire [CMP_W-1:0] rid_x = CMP_W'(rid_m);

  logic [ENTRIES-1:0] hit_v;
  logic [SPEC_W-1:0]  spec_v [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    wire [CMP_W-1:0] lo = CMP_W'(base_q[g]);
    wire [CMP_W-1:0] hi = lo + CMP_W'(len_q[g]);
    wire [RID_W-1:0] off = rid_m - base_q[g];
    assign hit_v[g]  = en_q[g] && (ctrl_q[g] == lk_ctrl) && (rid_x >= lo) && (rid_x < hi);
    assign spec_v[g] = SPEC_W'(off) + msi_q[g];
  end

  logic [SPEC_W-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_v[i]) pick = spec_v[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_spec  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|hit_v);
      rsp_spec  <= lk_valid ? pick : '0;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_spec == '0));
  // R11
  hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> $past(|en_q));
  // R2
  hit_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

endmodule

// File: tb/rid_msi_xlate_tb.sv
module rid_msi_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_field = '0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_rid = '0;
  logic [1:0]  lk_ctrl = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_spec;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_base [8];
  logic [1:0]  m_ctrl [8];
  logic [31:0] m_msi  [8];
  logic [16:0] m_len  [8];
  logic [7:0]  m_en;
  logic [15:0] m_mask;

  rid_msi_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
    .lk_rid(lk_rid), .lk_ctrl(lk_ctrl), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_spec(rsp_spec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [15:0] rid, input logic [1:0] c);
    int r, b, l;
    logic [31:0] s;
    r = int'(rid & m_mask);
    for (int i = 0; i < 8; i++) begin
      b = int'(m_base[i]);
      l = int'(m_len[i]);
      if (m_en[i] && m_ctrl[i] == c && r >= b && r < b + l) begin
        s = 32'(r - b) + m_msi[i];
        return {1'b1, s};
      end
    end
    return 33'd0;
  endfunction

  task automatic mdl_apply(input logic [2:0] f, input logic [2:0] i, input logic [31:0] d);
    case (f)
      3'd0: m_base[i] = d[15:0];
      3'd1: m_ctrl[i] = d[1:0];
      3'd2: m_msi[i]  = d;
      3'd3: m_len[i]  = d[16:0];
      3'd4: m_mask    = d[15:0];
      3'd5: m_en      = d[7:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] f, input logic [2:0] i, input logic [31:0] d);
    cfg_we = 1'b1; cfg_field = f; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mdl_apply(f, i, d);
  endtask

  task automatic set_ent(input int i, input logic [15:0] b, input logic [1:0] c,
                         input logic [31:0] m, input logic [16:0] l);
    wr(3'd0, 3'(i), 32'(b));
    wr(3'd1, 3'(i), 32'(c));
    wr(3'd2, 3'(i), m);
    wr(3'd3, 3'(i), 32'(l));
  endtask

  task automatic look(input logic [15:0] rid, input logic [1:0] c, input string req);
    logic [32:0] e;
    e = model(rid, c);
    lk_valid = 1'b1; lk_rid = rid; lk_ctrl = c;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " rsp"}, 64'({rsp_valid, rsp_hit, rsp_spec}), 64'({1'b1, e}));
  endtask

  task automatic look_exp(input logic [15:0] rid, input logic [1:0] c,
                          input logic h, input logic [31:0] s, input string req);
    lk_valid = 1'b1; lk_rid = rid; lk_ctrl = c;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " fixed"}, 64'({rsp_valid, rsp_hit, rsp_spec}), 64'({1'b1, h, s}));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_ctrl[i] = '0; m_msi[i] = '0; m_len[i] = '0;
    end
    m_en = '0; m_mask = 16'hFFFF;

    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;

    // R1: nothing enabled after reset
    for (int c = 0; c < 4; c++) begin
      look(16'h0000, 2'(c), "R1");
      look(16'hFFFF, 2'(c), "R1");
      look_exp(16'h1234, 2'(c), 1'b0, 32'd0, "R1 R7");
    end
    @(negedge clk);
    chk("R2 idle", 64'(rsp_valid), 64'd0);

    // R4 R3: full-space identity with default mask, exhaustive
    set_ent(0, 16'h0000, 2'd0, 32'd0, 17'h10000);
    wr(3'd5, 3'd0, 32'h01);
    for (int r = 0; r < 65536; r++) look(16'(r), 2'd0, "R4 R3");
    look_exp(16'hFFFF, 2'd0, 1'b1, 32'h0000FFFF, "R3 default mask");
    look_exp(16'h4321, 2'd1, 1'b0, 32'd0, "R6");

    // R3: mask keeps device and function only
    wr(3'd4, 3'd0, 32'h00FF);
    wr(3'd3, 3'd0, 32'h100);
    for (int r = 0; r < 65536; r += 97) look(16'(r), 2'd0, "R3");
    look_exp(16'hAB12, 2'd0, 1'b1, 32'h12, "R3 masked");
    wr(3'd4, 3'd0, 32'hFFFF);

    // R6: two controllers, one sees bit 15 inverted; controller 2 unreachable
    set_ent(0, 16'h0000, 2'd0, 32'h8000, 17'h08000);
    set_ent(1, 16'h8000, 2'd0, 32'h0000, 17'h08000);
    set_ent(2, 16'h0000, 2'd1, 32'h0000, 17'h10000);
    wr(3'd5, 3'd0, 32'h07);
    for (int r = 0; r < 65536; r += 61)
      for (int c = 0; c < 3; c++) look(16'(r), 2'(c), "R6");
    look_exp(16'h0123, 2'd0, 1'b1, 32'h8123, "R6 ctrl0");
    look_exp(16'h8123, 2'd0, 1'b1, 32'h0123, "R6 ctrl0 hi");
    look_exp(16'h8123, 2'd1, 1'b1, 32'h8123, "R6 ctrl1");
    look_exp(16'h8123, 2'd2, 1'b0, 32'd0, "R7 ctrl2");

    // R8: overlap on controller 3, lower index wins
    set_ent(3, 16'h0100, 2'd3, 32'h5000, 17'h100);
    set_ent(1, 16'h0180, 2'd3, 32'h9000, 17'h100);
    wr(3'd5, 3'd0, 32'h0A);
    for (int r = 16'h0F0; r < 16'h2A0; r++) look(16'(r), 2'd3, "R8");
    look_exp(16'h0180, 2'd3, 1'b1, 32'h9000, "R8 overlap");
    look_exp(16'h017F, 2'd3, 1'b1, 32'h507F, "R8 below");

    // R4: range edges and zero length
    set_ent(4, 16'h1000, 2'd2, 32'h40, 17'h10);
    set_ent(5, 16'h2000, 2'd2, 32'h77, 17'h0);
    wr(3'd5, 3'd0, 32'h30);
    look_exp(16'h0FFF, 2'd2, 1'b0, 32'd0, "R4 below");
    look_exp(16'h1000, 2'd2, 1'b1, 32'h40, "R4 first");
    look_exp(16'h100F, 2'd2, 1'b1, 32'h4F, "R4 last");
    look_exp(16'h1010, 2'd2, 1'b0, 32'd0, "R4 end excluded");
    look_exp(16'h2000, 2'd2, 1'b0, 32'd0, "R4 zero length");
    for (int r = 16'h0FF0; r < 16'h1020; r++) look(16'(r), 2'd2, "R4");

    // R5: wrap modulo 2^32
    set_ent(6, 16'hFF00, 2'd1, 32'hFFFF_FFF0, 17'h100);
    wr(3'd5, 3'd0, 32'h40);
    look_exp(16'hFF20, 2'd1, 1'b1, 32'h10, "R5 wrap");
    look_exp(16'hFF0F, 2'd1, 1'b1, 32'hFFFF_FFFF, "R5 top");
    for (int r = 16'hFF00; r <= 16'hFFFF; r++) look(16'(r), 2'd1, "R5");

    // R9: codes 6 and 7 change nothing
    cfg_we = 1'b1; cfg_field = 3'd6; cfg_idx = 3'd6; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_field = 3'd7;
    @(negedge clk);
    cfg_we = 1'b0;
    look_exp(16'hFF20, 2'd1, 1'b1, 32'h10, "R9 unused codes");

    // R10: write and lookup in the same cycle
    cfg_we = 1'b1; cfg_field = 3'd2; cfg_idx = 3'd6; cfg_wdata = 32'h1000;
    look_exp(16'hFF20, 2'd1, 1'b1, 32'h10, "R10 old");
    cfg_we = 1'b0;
    mdl_apply(3'd2, 3'd6, 32'h1000);
    look_exp(16'hFF20, 2'd1, 1'b1, 32'h1020, "R10 new");

    // R11: disabling an entry stops it matching
    wr(3'd5, 3'd0, 32'h00);
    look_exp(16'hFF20, 2'd1, 1'b0, 32'd0, "R11 disabled");
    for (int r = 0; r < 65536; r += 257) look(16'(r), 2'(r % 4), "R11");

    // R1: reset restores defaults
    wr(3'd4, 3'd0, 32'h000F);
    wr(3'd5, 3'd0, 32'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    m_en = '0; m_mask = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_ctrl[i] = '0; m_msi[i] = '0; m_len[i] = '0;
    end
    look_exp(16'h0000, 2'd0, 1'b0, 32'd0, "R1 after reset");
    set_ent(0, 16'h0000, 2'd0, 32'd0, 17'h10000);
    wr(3'd5, 3'd0, 32'h01);
    look_exp(16'hABCD, 2'd0, 1'b1, 32'h0000ABCD, "R1 mask restored");
    @(negedge clk);
    chk("R2 idle", 64'(rsp_valid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule